// File: doc/BRIEF.md
# Maskable Interrupt Status Unit

This unit collects the interrupt causes of a serial bus controller and presents them through a small register port. Ten causes are event-driven: a one-cycle pulse on the matching event input sets a sticky bit that holds until software reads a clear address. The other two causes are levels. One reports that the transmit FIFO has drained to its programmed threshold. The other reports that the receive FIFO has filled past its programmed threshold. Both follow the FIFO fill levels, which enter as inputs, and neither can be cleared.

A mask register selects which causes reach the single interrupt output. Software reads the masked view to find the cause. It then reads either the dedicated clear address of that cause or the combined clear address. Reading a clear address returns the bit's prior value in data bit 0. Read data is combinational and is valid while the read strobe is high. State changes take effect at the clock edge that ends the access.

Top module: `irq_status_unit`

## Requirements
- R1: The raw status at address 0x34 places the causes as follows: bit 0 RX underflow, bit 1 RX overflow, bit 2 RX threshold reached, bit 3 TX overflow, bit 4 TX at/below threshold, bit 5 read request, bit 6 TX abort, bit 7 RX done, bit 8 activity, bit 9 stop seen, bit 10 start seen, bit 11 general call; bits 15..12 read 0.
- R2: A pulse on `evt_pulse[b]` for an event-driven bit b (any bit except 2 and 4) sets that raw bit from the next cycle on, and it stays set until cleared; pulses on `evt_pulse[2]` and `evt_pulse[4]` have no effect.
- R3: Address 0x30 is a read/write 12-bit mask; address 0x2C reads raw AND mask; `irq_o` is high exactly when any masked bit is set, in the same cycle.
- R4: A read of a per-cause clear address returns that bit's prior value in data bit 0 and clears the bit from the next cycle: 0x44 bit 0, 0x48 bit 1, 0x4C bit 3, 0x50 bit 5, 0x54 bit 6, 0x58 bit 7, 0x5C bit 8, 0x60 bit 9, 0x64 bit 10, 0x68 bit 11.
- R5: A read of 0x40 returns in data bit 0 the OR of all event-driven sticky bits, and it clears all of them from the next cycle.
- R6: When a set pulse and a clear read hit the same bit in the same cycle, the bit is set afterwards.
- R7: Raw bit 4 is high while `tx_level` <= the TX threshold (read/write at 0x3C). Raw bit 2 is high while `rx_level` > the RX threshold (read/write at 0x38), that is, while the level is at least threshold+1. Clear reads do not affect either bit.
- R8: With the mask at 0, `irq_o` stays low whatever the raw status is.
- R9: Writes to 0x2C, 0x34 and the clear addresses change nothing. Reads of non-clear addresses change nothing. Reads of unmapped addresses return 0.
- R10: After reset the sticky bits, the mask and both thresholds are 0, and `irq_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_rd | input | 1 | Read strobe, one cycle per access |
| reg_wr | input | 1 | Write strobe |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, valid while reg_rd is high |
| evt_pulse | input | 12 | One-cycle set pulses per cause |
| tx_level | input | LVL_W | Transmit FIFO fill level |
| rx_level | input | LVL_W | Receive FIFO fill level |
| irq_o | output | 1 | Combined interrupt |

## Verification
The two functions that can meet in one cycle are a set pulse from a source and a clear read aimed at the same bit, either through its own address or the combined one. The bench drives the event pulse and the read strobe during the same clock period for every event-driven bit. It checks that the returned data shows the value held before the edge. It also checks that a following raw read shows the bit still set. The level-derived bits are probed the same way: a combined clear is issued while they are active, and they must be unaffected.

// File: rtl/irq_stat_pkg.sv
package irq_stat_pkg;

    localparam int NSRC = 12;

    localparam int B_RXU = 0;
    localparam int B_RXO = 1;
    localparam int B_RXF = 2;
    localparam int B_TXO = 3;
    localparam int B_TXE = 4;
    localparam int B_RDR = 5;
    localparam int B_TXA = 6;
    localparam int B_RXD = 7;
    localparam int B_ACT = 8;
    localparam int B_STP = 9;
    localparam int B_STA = 10;
    localparam int B_GCL = 11;

    // bits held in flops; bits 2 and 4 follow FIFO levels
    localparam logic [NSRC-1:0] STICKY_MASK = 12'hFEB;

    localparam logic [7:0] A_MASKED = 8'h2C;
    localparam logic [7:0] A_MASK   = 8'h30;
    localparam logic [7:0] A_RAW    = 8'h34;
    localparam logic [7:0] A_RXTHR  = 8'h38;
    localparam logic [7:0] A_TXTHR  = 8'h3C;
    localparam logic [7:0] A_CLRALL = 8'h40;

    // per-cause clear-on-read address; 8'hFF marks a level bit
    function automatic logic [7:0] clr_addr(input int b);
        case (b)
            B_RXU:   clr_addr = 8'h44;
            B_RXO:   clr_addr = 8'h48;
            B_TXO:   clr_addr = 8'h4C;
            B_RDR:   clr_addr = 8'h50;
            B_TXA:   clr_addr = 8'h54;
            B_RXD:   clr_addr = 8'h58;
            B_ACT:   clr_addr = 8'h5C;
            B_STP:   clr_addr = 8'h60;
            B_STA:   clr_addr = 8'h64;
            B_GCL:   clr_addr = 8'h68;
            default: clr_addr = 8'hFF;
        endcase
    endfunction

endpackage

// File: rtl/irq_clr_decode.sv
module irq_clr_decode
    import irq_stat_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr,
    output logic [NSRC-1:0]   clr_one,
    output logic              clr_all
);

    for (genvar g = 0; g < NSRC; g++) begin : g_dec
        if (STICKY_MASK[g]) begin : g_hit
            assign clr_one[g] = rd && (addr == ADDR_W'(clr_addr(g)));
        end else begin : g_none
            assign clr_one[g] = 1'b0;
        end
    end

    assign clr_all = rd && (addr == ADDR_W'(A_CLRALL));

endmodule

// File: rtl/irq_sticky_bank.sv
module irq_sticky_bank #(
    parameter int            N    = 12,
    parameter logic [N-1:0]  KEEP = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] q
);

    for (genvar g = 0; g < N; g++) begin : g_bit
        if (KEEP[g]) begin : g_flop
            logic bit_d, bit_q;
            // set takes priority over a same-cycle clear
            always_comb bit_d = set[g] | (bit_q & ~clr[g]);
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) bit_q <= 1'b0;
                else        bit_q <= bit_d;
            end
            assign q[g] = bit_q;
        end else begin : g_tie
            assign q[g] = 1'b0;
        end
    end

endmodule

// File: rtl/irq_level_src.sv
module irq_level_src #(
    parameter int LVL_W = 4
) (
    input  logic [LVL_W-1:0] tx_level,
    input  logic [LVL_W-1:0] tx_thr,
    input  logic [LVL_W-1:0] rx_level,
    input  logic [LVL_W-1:0] rx_thr,
    output logic             tx_low,
    output logic             rx_high
);

    assign tx_low  = (tx_level <= tx_thr);
    assign rx_high = (rx_level >  rx_thr);

endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
    import irq_stat_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    parameter int LVL_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [NSRC-1:0]   evt_pulse,
    input  logic [LVL_W-1:0]  tx_level,
    input  logic [LVL_W-1:0]  rx_level,
    output logic              irq_o
);

    typedef struct packed {
        logic [NSRC-1:0]  mask;
        logic [LVL_W-1:0] tx_thr;
        logic [LVL_W-1:0] rx_thr;
    } cfg_t;

    cfg_t            cfg_d, cfg_q;
    logic [NSRC-1:0] clr_one;
    logic            clr_all;
    logic [NSRC-1:0] clr_vec;
    logic [NSRC-1:0] sticky_q;
    logic            tx_low, rx_high;
    logic [NSRC-1:0] level_vec;
    logic [NSRC-1:0] raw_st;
    logic [NSRC-1:0] masked_st;
    logic [NSRC-1:0] mask_q;

    // configuration registers, next-state side
    always_comb begin
        cfg_d = cfg_q;
        if (reg_wr) begin
            if (reg_addr == ADDR_W'(A_MASK))  cfg_d.mask   = reg_wdata[NSRC-1:0];
            if (reg_addr == ADDR_W'(A_TXTHR)) cfg_d.tx_thr = reg_wdata[LVL_W-1:0];
            if (reg_addr == ADDR_W'(A_RXTHR)) cfg_d.rx_thr = reg_wdata[LVL_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign mask_q = cfg_q.mask;

    irq_clr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .rd      (reg_rd),
        .addr    (reg_addr),
        .clr_one (clr_one),
        .clr_all (clr_all)
    );

    assign clr_vec = clr_one | {NSRC{clr_all}};

    irq_sticky_bank #(.N(NSRC), .KEEP(STICKY_MASK)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (evt_pulse & STICKY_MASK),
        .clr   (clr_vec),
        .q     (sticky_q)
    );

    irq_level_src #(.LVL_W(LVL_W)) u_lvl (
        .tx_level (tx_level),
        .tx_thr   (cfg_q.tx_thr),
        .rx_level (rx_level),
        .rx_thr   (cfg_q.rx_thr),
        .tx_low   (tx_low),
        .rx_high  (rx_high)
    );

    always_comb begin
        level_vec        = '0;
        level_vec[B_TXE] = tx_low;
        level_vec[B_RXF] = rx_high;
    end

    assign raw_st    = sticky_q | level_vec;
    assign masked_st = raw_st & cfg_q.mask;
    assign irq_o     = |masked_st;

    // read data path
    always_comb begin
        reg_rdata = '0;
        if (reg_rd) begin
            if (reg_addr == ADDR_W'(A_MASKED)) reg_rdata = DATA_W'(masked_st);
            if (reg_addr == ADDR_W'(A_MASK))   reg_rdata = DATA_W'(cfg_q.mask);
            if (reg_addr == ADDR_W'(A_RAW))    reg_rdata = DATA_W'(raw_st);
            if (reg_addr == ADDR_W'(A_TXTHR))  reg_rdata = DATA_W'(cfg_q.tx_thr);
            if (reg_addr == ADDR_W'(A_RXTHR))  reg_rdata = DATA_W'(cfg_q.rx_thr);
            if (reg_addr == ADDR_W'(A_CLRALL)) reg_rdata = DATA_W'(|sticky_q);
            for (int b = 0; b < NSRC; b++) begin
                if (STICKY_MASK[b] && reg_addr == ADDR_W'(clr_addr(b)))
                    reg_rdata = DATA_W'(sticky_q[b]);
            end
        end
    end

endmodule

// File: rtl/irq_status_unit_chk.sv
module irq_status_unit_chk
    import irq_stat_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_rd,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [NSRC-1:0]   evt_pulse,
    input logic [NSRC-1:0]   sticky,
    input logic [NSRC-1:0]   level_vec,
    input logic [NSRC-1:0]   mask,
    input logic              irq
);

    a_r2_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt_pulse & STICKY_MASK) != '0) |=>
        ((sticky & $past(evt_pulse & STICKY_MASK)) == $past(evt_pulse & STICKY_MASK)));

    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_rd && ((evt_pulse & STICKY_MASK) == '0)) |=> $stable(sticky));

    a_r5_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == ADDR_W'(A_CLRALL) && ((evt_pulse & STICKY_MASK) == '0))
        |=> (sticky == '0));

    a_r6_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == ADDR_W'(A_CLRALL) && evt_pulse[B_RXU]) |=> sticky[B_RXU]);

    a_r7_levels_not_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ((sticky & ~STICKY_MASK) == '0));

    a_r8_mask_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |-> !irq);

    a_r3_irq_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (((sticky | level_vec) & mask) != '0));

endmodule

bind irq_status_unit irq_status_unit_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .evt_pulse (evt_pulse),
    .sticky    (sticky_q),
    .level_vec (level_vec),
    .mask      (mask_q),
    .irq       (irq_o)
);

// File: tb/irq_status_unit_test.sv
`timescale 1ns/1ps
module irq_status_unit_test;
    import irq_stat_pkg::*;

    localparam int ADDR_W = 8;
    localparam int DATA_W = 16;
    localparam int LVL_W  = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_rd = 1'b0;
    logic              reg_wr = 1'b0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic [DATA_W-1:0] reg_wdata = '0;
    logic [DATA_W-1:0] reg_rdata;
    logic [NSRC-1:0]   evt_pulse = '0;
    logic [LVL_W-1:0]  tx_level = '0;
    logic [LVL_W-1:0]  rx_level = '0;
    logic              irq_o;

    irq_status_unit #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LVL_W(LVL_W)) uut (
        .clk(clk), .rst_n(rst_n), .reg_rd(reg_rd), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .evt_pulse(evt_pulse), .tx_level(tx_level), .rx_level(rx_level),
        .irq_o(irq_o)
    );

    always #4 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;

    // reference state
    logic [NSRC-1:0]  m_sticky = '0;
    logic [NSRC-1:0]  m_mask   = '0;
    logic [LVL_W-1:0] m_txthr  = '0;
    logic [LVL_W-1:0] m_rxthr  = '0;
    localparam logic [NSRC-1:0] EVT_BITS = 12'b1111_1110_1011;

    function automatic logic [NSRC-1:0] m_raw();
        logic [NSRC-1:0] r;
        r = m_sticky;
        if (tx_level <= m_txthr) r[4] = 1'b1;
        if (rx_level >  m_rxthr) r[2] = 1'b1;
        return r;
    endfunction

    function automatic logic [7:0] m_clr(input int b);
        logic [7:0] t [12];
        t = '{8'h44, 8'h48, 8'hFF, 8'h4C, 8'hFF, 8'h50,
              8'h54, 8'h58, 8'h5C, 8'h60, 8'h64, 8'h68};
        return t[b];
    endfunction

    function automatic logic [DATA_W-1:0] m_read(input logic [7:0] a);
        logic [DATA_W-1:0] v;
        v = '0;
        case (a)
            8'h2C: v = DATA_W'(m_raw() & m_mask);
            8'h30: v = DATA_W'(m_mask);
            8'h34: v = DATA_W'(m_raw());
            8'h38: v = DATA_W'(m_rxthr);
            8'h3C: v = DATA_W'(m_txthr);
            8'h40: v = DATA_W'(|m_sticky);
            default: begin
                for (int b = 0; b < NSRC; b++)
                    if (EVT_BITS[b] && m_clr(b) == a) v = DATA_W'(m_sticky[b]);
            end
        endcase
        return v;
    endfunction

    task automatic chk(input string req, input logic [DATA_W-1:0] got, input logic [DATA_W-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    task automatic chk_irq(input string req);
        #1;
        chk(req, DATA_W'(irq_o), DATA_W'(|(m_raw() & m_mask)));
    endtask

    // read with optional same-cycle event pulse; checks returned data
    task automatic rd(input string req, input logic [7:0] a, input logic [NSRC-1:0] ev);
        logic [DATA_W-1:0] exp;
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a; evt_pulse = ev;
        exp = m_read(a);
        #1 chk(req, reg_rdata, exp);
        @(posedge clk);
        #1 reg_rd = 1'b0; evt_pulse = '0;
        if (a == 8'h40) m_sticky = '0;
        for (int b = 0; b < NSRC; b++)
            if (EVT_BITS[b] && m_clr(b) == a) m_sticky[b] = 1'b0;
        m_sticky = m_sticky | (ev & EVT_BITS);
    endtask

    task automatic wr(input logic [7:0] a, input logic [DATA_W-1:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        #1 reg_wr = 1'b0;
        case (a)
            8'h30: m_mask  = d[NSRC-1:0];
            8'h38: m_rxthr = d[LVL_W-1:0];
            8'h3C: m_txthr = d[LVL_W-1:0];
            default: ;
        endcase
    endtask

    task automatic pulse(input logic [NSRC-1:0] ev);
        @(negedge clk);
        evt_pulse = ev;
        @(posedge clk);
        #1 evt_pulse = '0;
        m_sticky = m_sticky | (ev & EVT_BITS);
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        logic [NSRC-1:0] lfsr;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R10 reset state: only the TX level bit (level 0 <= thr 0)
        chk_irq("R10 irq after reset");
        rd("R10 raw after reset", 8'h34, '0);
        rd("R10 mask after reset", 8'h30, '0);
        rd("R10 thresholds after reset", 8'h38, '0);

        // R2/R4: every event bit, set then cleared through its own address
        tx_level = 4'd1;  // TX level bit off
        for (int b = 0; b < NSRC; b++) begin
            if (EVT_BITS[b]) begin
                pulse(NSRC'(1) << b);
                rd("R2 raw after event", 8'h34, '0);
                rd("R4 clear read returns 1", m_clr(b), '0);
                rd("R4 raw after clear", 8'h34, '0);
                rd("R4 second clear read returns 0", m_clr(b), '0);
            end
        end

        // R2: pulses on level positions do nothing
        pulse(12'h014);
        rd("R2 level-position pulses ignored", 8'h34, '0);

        // R7: exhaustive threshold/level sweep
        for (int t = 0; t < 16; t++) begin
            wr(8'h3C, DATA_W'(t));
            wr(8'h38, DATA_W'(15 - t));
            for (int l = 0; l < 16; l++) begin
                @(negedge clk);
                tx_level = LVL_W'(l);
                rx_level = LVL_W'(15 - l);
                rd("R7 level bits vs thresholds", 8'h34, '0);
            end
        end
        rd("R7 TX threshold readback", 8'h3C, '0);

        // R7: combined clear while both levels active leaves them set
        wr(8'h3C, 16'd5); wr(8'h38, 16'd2);
        @(negedge clk); tx_level = 4'd3; rx_level = 4'd9;
        pulse(EVT_BITS);
        rd("R5 combined clear returns 1", 8'h40, '0);
        rd("R7 levels survive combined clear", 8'h34, '0);
        rd("R5 combined clear returns 0 when empty", 8'h40, '0);

        // R3: single-bit masks, then pseudo-random masks
        pulse(EVT_BITS);
        for (int b = 0; b < NSRC; b++) begin
            wr(8'h30, DATA_W'(1) << b);
            rd("R3 masked single bit", 8'h2C, '0);
            chk_irq("R3 irq single bit");
        end
        lfsr = 12'hACE;
        for (int i = 0; i < 40; i++) begin
            lfsr = {lfsr[10:0], lfsr[11] ^ lfsr[10] ^ lfsr[9] ^ lfsr[3]};
            if (i % 3 == 0) pulse(lfsr ^ 12'h5A5);
            if (i % 4 == 1) rd("R4 clear inside sweep", m_clr(i % 12), '0);
            wr(8'h30, DATA_W'(lfsr));
            rd("R3 masked pattern", 8'h2C, '0);
            chk_irq("R3 irq pattern");
        end

        // R8: mask zero with everything set
        pulse(EVT_BITS);
        wr(8'h30, 16'h0000);
        chk_irq("R8 irq with zero mask");
        chk("R8 irq low", DATA_W'(irq_o), '0);
        rd("R8 masked reads 0", 8'h2C, '0);

        // R6: set and clear in the same cycle
        rd("R5 clear before collision", 8'h40, '0);
        for (int b = 0; b < NSRC; b++) begin
            if (EVT_BITS[b]) begin
                rd("R6 clear read during set", m_clr(b), NSRC'(1) << b);
                rd("R6 bit set after collision", 8'h34, '0);
            end
        end
        rd("R6 combined clear during set", 8'h40, 12'h801);
        rd("R6 raw after combined collision", 8'h34, '0);

        // R9: ignored writes, non-clearing reads, unmapped reads
        wr(8'h34, 16'h0000); wr(8'h2C, 16'h0000);
        wr(8'h40, 16'hFFFF); wr(8'h44, 16'hFFFF);
        rd("R9 raw after ignored writes", 8'h34, '0);
        rd("R9 raw read does not clear", 8'h34, '0);
        rd("R9 masked read does not clear", 8'h2C, '0);
        rd("R9 raw still held", 8'h34, '0);
        rd("R9 unmapped read", 8'h7C, '0);
        rd("R9 unmapped read 0x00", 8'h00, '0);

        // R1: layout of a single cause at its position
        rd("R1 flush", 8'h40, '0);
        pulse(NSRC'(1) << B_GCL);
        chk("R1 general call at bit 11", DATA_W'(1) << 11, DATA_W'(m_raw() & 12'h800));
        rd("R1 raw layout", 8'h34, '0);

        summary();
    end

endmodule